// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is the register access port that a host processor sees. It has a 16-bit data path, a 3-bit address, an active-low select and two strobe pins, and it fronts a file of eight 16-bit registers. A mode input sets how the strobe pins are read. In split mode one pin is a write strobe and the other a read strobe. In strobe mode the first pin is a single data strobe and the second is a direction line, where high means read and low means write.

All control pins are taken into the internal clock through a two-flop synchronizer. A write is seen as the rising edge of the synchronized write or data strobe, qualified by select. On that edge the data and address inputs go into a holding register. One clock later the holding register is written into the register file. A qualified read raises the output enable, and the addressed entry is placed on the output data. The output enable is the tri-state control for the shared bus pins that sit outside this block. At all other times the output enable is low and the output data is zero.

Top module: `host_bus_port`

## Requirements
- R1: With mode_i = 0 and cs_ni low, a low-to-high transition of wr_ni writes data_i into the entry selected by addr_i, where addr_i bit 2 is the MSB.
- R2: With mode_i = 0, while cs_ni and rd_ni are both low, data_oe_o is 1 and data_o carries the entry selected by addr_i, with bit 15 as the MSB.
- R3: With mode_i = 1, a low-to-high transition of wr_ni (data strobe) while rd_ni (direction) is low and cs_ni is low writes data_i into the entry selected by addr_i.
- R4: With mode_i = 1, while wr_ni is low, rd_ni is high and cs_ni is low, data_oe_o is 1 and data_o carries the addressed entry.
- R5: In either mode, a strobe edge while cs_ni is high writes nothing.
- R6: data_oe_o follows the read qualification two clock edges after the pins change. A written value is readable after the third rising edge that follows the first edge sampling the strobe high.
- R7: When no qualified read is active, including right after reset, data_oe_o is 0 and data_o is zero.
- R8: The active-low asynchronous reset clears the holding register and all eight entries to zero. After reset the synchronized mode is 0 (split mode) and the strobes and select are idle.
- R9: No write occurs on the rising edge of the read strobe in mode 0, or on a data strobe edge with the direction line high in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: split read/write strobes, 1: data strobe plus direction |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe (mode 0) or data strobe (mode 1) |
| rd_ni | input | 1 | Read strobe (mode 0) or direction, high = read (mode 1) |
| addr_i | input | 3 | Register address |
| data_i | input | 16 | Inbound half of the data bus |
| data_o | output | 16 | Outbound half of the data bus |
| data_oe_o | output | 1 | Bus drive enable; bus is high-impedance when 0 |

## Verification
The assertions take it for granted that the host never asserts the read and write strobes together in split mode. They also assume that address, data and select stay stable from before a strobe edge until the write has been committed, because these are sampled several clocks after the pin transition. The bench drives every pin on the falling clock edge, holds address, data and select for four clocks after each write strobe rises, and leaves three idle clocks between transfers and around mode changes. A reference model built from a queue of sampled pin states predicts the enable and the data on every clock.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    BUS_SPLIT  = 1'b0,
    BUS_STROBE = 1'b1
  } bus_mode_e;

  // strb_n: write/data strobe pin; aux_n: read strobe or direction pin
  typedef struct packed {
    logic mode;
    logic cs_n;
    logic strb_n;
    logic aux_n;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{mode: 1'b0, cs_n: 1'b1, strb_n: 1'b1, aux_n: 1'b1};
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int unsigned    WIDTH   = 4,
  parameter int unsigned    STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbp_decode.sv
module hbp_decode
  import hbp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  ctrl_t ctl_i,
  output logic  wr_pulse_o,
  output logic  rd_en_o
);
  bus_mode_e mode;
  logic      strb_prev_q;
  logic      wr_qual;
  logic      strb_rise;

  assign mode = bus_mode_e'(ctl_i.mode);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_prev_q <= 1'b1;
    else         strb_prev_q <= ctl_i.strb_n;
  end

  // active-low strobe returning high marks the write
  assign strb_rise = ctl_i.strb_n & ~strb_prev_q;

  always_comb begin
    unique case (mode)
      BUS_SPLIT:  begin
        wr_qual = ~ctl_i.cs_n;
        rd_en_o = ~ctl_i.cs_n & ~ctl_i.aux_n;
      end
      BUS_STROBE: begin
        wr_qual = ~ctl_i.cs_n & ~ctl_i.aux_n;
        rd_en_o = ~ctl_i.cs_n & ~ctl_i.strb_n & ctl_i.aux_n;
      end
      default: begin
        wr_qual = 1'b0;
        rd_en_o = 1'b0;
      end
    endcase
  end

  assign wr_pulse_o = strb_rise & wr_qual;
endmodule

// File: rtl/hbp_regfile.sv
module hbp_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_pulse_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [DATA_W-1:0]       data_o,
  output logic                    oe_o,
  output logic                    commit_o,
  output logic [ADDR_W-1:0]       hold_addr_o,
  output logic [DATA_W-1:0]       hold_data_o,
  output logic [DEPTH*DATA_W-1:0] mem_flat_o
);
  logic [DATA_W-1:0] hold_data_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic              commit_q;
  logic [DATA_W-1:0] entry_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_data_q <= '0;
      hold_addr_q <= '0;
      commit_q    <= 1'b0;
    end else begin
      commit_q <= wr_pulse_i;
      if (wr_pulse_i) begin
        hold_data_q <= data_i;
        hold_addr_q <= addr_i;
      end
    end
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         entry_q[g] <= '0;
      else if (commit_q && hold_addr_q == ADDR_W'(g))      entry_q[g] <= hold_data_q;
    end
    assign mem_flat_o[g*DATA_W +: DATA_W] = entry_q[g];
  end

  assign data_o      = rd_en_i ? entry_q[addr_i] : '0;
  assign oe_o        = rd_en_i;
  assign commit_o    = commit_q;
  assign hold_addr_o = hold_addr_q;
  assign hold_data_o = hold_data_q;
endmodule

// File: rtl/host_bus_port.sv
module host_bus_port
  import hbp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t                    ctl_raw;
  ctrl_t                    ctl_sync;
  logic [CTRL_W-1:0]        ctl_sync_bits;
  logic                     wr_pulse;
  logic                     rd_en;
  logic                     commit_q;
  logic [ADDR_W-1:0]        hold_addr;
  logic [DATA_W-1:0]        hold_data;
  logic [DEPTH*DATA_W-1:0]  mem_flat;

  assign ctl_raw = '{mode: mode_i, cs_n: cs_ni, strb_n: wr_ni, aux_n: rd_ni};

  hbp_sync #(
    .WIDTH  (CTRL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTRL_W'(CTRL_IDLE))
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_sync_bits)
  );

  assign ctl_sync = ctrl_t'(ctl_sync_bits);

  hbp_decode u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_i     (ctl_sync),
    .wr_pulse_o(wr_pulse),
    .rd_en_o   (rd_en)
  );

  hbp_regfile #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_pulse_i (wr_pulse),
    .rd_en_i    (rd_en),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .data_o     (data_o),
    .oe_o       (data_oe_o),
    .commit_o   (commit_q),
    .hold_addr_o(hold_addr),
    .hold_data_o(hold_data),
    .mem_flat_o (mem_flat)
  );
endmodule

// File: rtl/hbp_checker.sv
module hbp_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cs_ni,
  input logic                    data_oe_o,
  input logic                    wr_pulse,
  input logic                    commit_q,
  input logic [ADDR_W-1:0]       hold_addr,
  input logic [DATA_W-1:0]       hold_data,
  input logic [DEPTH*DATA_W-1:0] mem_flat
);
  logic [1:0] age_q;
  logic       aged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign aged = (age_q == 2'd3);

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aged && data_oe_o) |-> !$past(cs_ni, 2)); // R2

  AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aged && wr_pulse) |-> !$past(cs_ni, 2)); // R5

  AST_COMMIT_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |=> (mem_flat[int'($past(hold_addr))*DATA_W +: DATA_W] == $past(hold_data))); // R1

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse |-> !data_oe_o); // R9

  AST_SINGLE_WRITE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse |=> !wr_pulse); // R6
endmodule

bind host_bus_port hbp_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .data_oe_o(data_oe_o),
  .wr_pulse (wr_pulse),
  .commit_q (commit_q),
  .hold_addr(hold_addr),
  .hold_data(hold_data),
  .mem_flat (mem_flat)
);

// File: tb/sim_host_bus_port.sv
`timescale 1ns/1ps
module sim_host_bus_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic        cs_ni = 1'b1;
  logic        wr_ni = 1'b1;
  logic        rd_ni = 1'b1;
  logic [2:0]  addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        data_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  host_bus_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .cs_ni(cs_ni),
    .wr_ni(wr_ni), .rd_ni(rd_ni), .addr_i(addr_i), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  typedef struct packed {
    logic        mode;
    logic        cs;
    logic        wr;
    logic        rd;
    logic [2:0]  addr;
    logic [15:0] data;
  } pins_t;

  localparam pins_t IDLE = '{mode: 1'b0, cs: 1'b1, wr: 1'b1, rd: 1'b1, addr: 3'd0, data: 16'd0};

  pins_t       smp_q[$];
  logic [15:0] ref_mem [8];
  bit          ref_pulse;
  bit          ref_cmt;
  logic [2:0]  ref_cmt_a;
  logic [15:0] ref_cmt_d;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: pins sampled per edge, two-deep sync seen via queue
  always @(posedge clk) begin
    if (!rst_ni) begin
      smp_q = {IDLE, IDLE, IDLE};
      for (int i = 0; i < 8; i++) ref_mem[i] = '0;
      ref_pulse = 0;
      ref_cmt = 0;
    end else begin
      pins_t cur, s2, s3;
      bit    exp_oe;
      cur = '{mode: mode_i, cs: cs_ni, wr: wr_ni, rd: rd_ni, addr: addr_i, data: data_i};
      if (ref_cmt) ref_mem[ref_cmt_a] = ref_cmt_d;
      ref_cmt = ref_pulse;
      if (ref_pulse) begin
        ref_cmt_a = cur.addr;
        ref_cmt_d = cur.data;
      end
      smp_q.push_front(cur);
      void'(smp_q.pop_back());
      s2 = smp_q[1];
      s3 = smp_q[2];
      ref_pulse = s2.wr && !s3.wr && !s2.cs && (!s2.mode || !s2.rd);
      exp_oe = !s2.cs && (s2.mode ? (!s2.wr && s2.rd) : !s2.rd);
      #3;
      if (rst_ni) begin
        chk("R6 R7 oe", {15'd0, data_oe_o}, {15'd0, exp_oe});
        chk("R2 R4 R7 data", data_o, exp_oe ? ref_mem[addr_i] : 16'd0);
      end
    end
  end

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    mode_i = m; cs_ni = 1'b1; wr_ni = 1'b1; rd_ni = m ? 1'b0 : 1'b1;
    idle_n(4);
  endtask

  // one write cycle; sel=0 drives cs high to test ignore; dir used in mode 1
  task automatic do_write(input logic [2:0] a, input logic [15:0] d, input logic sel, input logic dir);
    @(negedge clk);
    addr_i = a; data_i = d; cs_ni = ~sel;
    if (mode_i) rd_ni = dir;
    @(negedge clk); wr_ni = 1'b0;
    idle_n(2);      wr_ni = 1'b1;
    idle_n(4);      cs_ni = 1'b1;
    if (mode_i) rd_ni = 1'b0;
    idle_n(3);
  endtask

  task automatic do_read(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr_i = a; cs_ni = 1'b0;
    if (mode_i) begin rd_ni = 1'b1; wr_ni = 1'b0; end
    else        rd_ni = 1'b0;
    @(negedge clk);
    chk({tag, " R6 oe after one edge"}, {15'd0, data_oe_o}, 16'd0);
    @(negedge clk);
    chk({tag, " R6 oe after two edges"}, {15'd0, data_oe_o}, 16'd1);
    chk({tag, " data"}, data_o, exp);
    cs_ni = 1'b1; wr_ni = 1'b1;
    rd_ni = mode_i ? 1'b0 : 1'b1;
    idle_n(3);
    chk({tag, " R7 released"}, {15'd0, data_oe_o}, 16'd0);
  endtask

  initial begin
    idle_n(3);
    chk("R7 reset oe", {15'd0, data_oe_o}, 16'd0);
    chk("R7 reset data", data_o, 16'd0);
    @(negedge clk); rst_ni = 1'b1;
    idle_n(3);
    for (int a = 0; a < 8; a++) do_read(3'(a), 16'h0000, "R8 cleared");

    do_write(3'd3, 16'hA5A5, 1'b1, 1'b0);
    do_read(3'd3, 16'hA5A5, "R1 R2 split");
    do_write(3'd7, 16'h8001, 1'b1, 1'b0);
    do_read(3'd7, 16'h8001, "R2 msb");
    do_read(3'd3, 16'hA5A5, "R1 kept");
    do_write(3'd5, 16'h5555, 1'b0, 1'b0);
    do_read(3'd5, 16'h0000, "R5 split no select");
    do_read(3'd4, 16'h0000, "R9 read edge no write");

    set_mode(1'b1);
    do_write(3'd5, 16'h1234, 1'b1, 1'b0);
    do_read(3'd5, 16'h1234, "R3 R4 strobe");
    do_write(3'd6, 16'hBEEF, 1'b0, 1'b0);
    do_read(3'd6, 16'h0000, "R5 strobe no select");
    data_i = 16'hFFFF;
    do_write(3'd6, 16'hFFFF, 1'b1, 1'b1);
    do_read(3'd6, 16'h0000, "R9 direction high");
    do_write(3'd0, 16'h00FF, 1'b1, 1'b0);
    do_read(3'd0, 16'h00FF, "R3 addr0");

    set_mode(1'b0);
    do_read(3'd5, 16'h1234, "R2 back to split");
    @(negedge clk);
    rst_ni = 1'b0; cs_ni = 1'b1; wr_ni = 1'b1; rd_ni = 1'b1; mode_i = 1'b0;
    idle_n(2);
    rst_ni = 1'b1;
    idle_n(3);
    do_read(3'd5, 16'h0000, "R8 reset clears");
    do_read(3'd7, 16'h0000, "R8 reset clears msb");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    idle_n(1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule